// File: doc/BRIEF.md
# Interleaving Multi-Port Bank Router

This block sits between a set of processor request ports and an array of memory banks. Each port offers a word address with a valid flag. The router serves the ports in a fixed rotation and takes one reference per port per turn. Ports that have nothing to send are passed over. The chosen address is split into a bank number and a word offset inside that bank. A two-bit mode input selects how the split is made: low-order, high-order, cache-line or split-field n-way block interleaving.

The routed request is held in one output register. It is shown to exactly one bank as a valid strobe, together with the offset and the number of the port it came from. The request stays there until that bank signals ready. Only then does the router take the next request. The rotation pointer moves past a port at the moment its request is captured. A port whose request is blocked behind a busy bank therefore keeps its turn until the request is delivered.

Defaults: 4 ports, 8 banks, 12-bit addresses, 4-word lines, 2-way blocks. The bank count, line length and way count are powers of two, and the way count is no larger than the bank count.

Top module: `bank_router`

## Requirements
- R1: In the cycle after reset is applied, no bank valid strobe is raised and the rotation restarts at port 0.
- R2: With mode 0 (low-order), the bank is address bits [2:0] and the offset is bits [11:3].
- R3: With mode 1 (high-order), the bank is address bits [11:9] and the offset is bits [8:0].
- R4: With mode 2 (cache-line, 4-word lines), the bank is bits [4:2] and the offset is {bits[11:5], bits[1:0]}.
- R5: With mode 3 (2-way block), the bank is {bits[4:3], bit[0]} and the offset is {bits[11:5], bits[2:1]}.
- R6: At most one bank valid strobe is high, and it shows the routed request in the cycle after the port's ready pulse. `bank_src` carries the port number.
- R7: When every port keeps requesting, grants go 0, 1, 2, 3, 0, ..., one reference per port per turn.
- R8: Ports without a valid request are skipped. With only ports 1 and 3 active, grants alternate 1, 3, 1, 3.
- R9: While the target bank is not ready, the bank strobe, offset and source hold, and no port gets ready. Ready on other banks does not release the stall.
- R10: A port's ready is only raised while that port's valid is high.
- R11: With all banks ready, a new request is routed every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Interleave scheme: 0 low, 1 high, 2 line, 3 block |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_addr | input | NUM_PORTS*ADDR_W | Word addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| req_ready | output | NUM_PORTS | Request taken this cycle, one bit per port |
| bank_valid | output | NUM_BANKS | One-hot request strobe to the banks |
| bank_ready | input | NUM_BANKS | Bank can accept, one bit per bank |
| bank_offset | output | ADDR_W-log2(NUM_BANKS) | Word offset inside the target bank |
| bank_src | output | log2(NUM_PORTS) | Port the routed request came from |

## Verification
`req_ready` is combinational from the output register and the current valids. The bench checks it one time step after it drives the inputs on a falling edge. A granted request passes through one register, so its bank strobe, offset and source are checked at the next falling edge, one cycle later. Sequences in the rotation and stall tests are read at consecutive falling edges, where each edge holds the result of the grant made one cycle before. When the bank ready comes back, the next request is likewise expected one falling edge later.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;
  typedef enum logic [1:0] {
    MAP_LOW   = 2'd0,
    MAP_HIGH  = 2'd1,
    MAP_LINE  = 2'd2,
    MAP_BLOCK = 2'd3
  } map_mode_e;
endpackage

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
  import bank_router_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_BANKS  = 8,
  parameter int LINE_WORDS = 4,
  parameter int BLOCK_WAYS = 2
) (
  input  logic [ADDR_W-1:0]                     addr,
  input  map_mode_e                             mode,
  output logic [$clog2(NUM_BANKS)-1:0]          bank,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]   offset
);
  localparam int LB    = $clog2(NUM_BANKS);
  localparam int LP    = $clog2(LINE_WORDS);
  localparam int LN    = $clog2(BLOCK_WAYS);
  localparam int OFF_W = ADDR_W - LB;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Split-field bank: group bits above the line field, way bits at the bottom.
  function automatic logic [ADDR_W-1:0] split_bank(input logic [ADDR_W-1:0] a, input int ln);
    logic [ADDR_W-1:0] way_mask;
    logic [ADDR_W-1:0] grp_mask;
    way_mask = (ONE << ln) - ONE;
    grp_mask = (ONE << (LB - ln)) - ONE;
    return (((a >> (ln + LP)) & grp_mask) << ln) | (a & way_mask);
  endfunction

  // Split-field offset: bits above bank field, then the in-line word bits.
  function automatic logic [ADDR_W-1:0] split_off(input logic [ADDR_W-1:0] a, input int ln);
    logic [ADDR_W-1:0] line_mask;
    line_mask = (ONE << LP) - ONE;
    return ((a >> (LB + LP)) << LP) | ((a >> ln) & line_mask);
  endfunction

  logic [ADDR_W-1:0] bank_w;
  logic [ADDR_W-1:0] off_w;

  always_comb begin
    bank_w = '0;
    off_w  = '0;
    unique case (mode)
      MAP_LOW: begin
        bank_w = ADDR_W'(addr[LB-1:0]);
        off_w  = ADDR_W'(addr[ADDR_W-1:LB]);
      end
      MAP_HIGH: begin
        bank_w = ADDR_W'(addr[ADDR_W-1:OFF_W]);
        off_w  = ADDR_W'(addr[OFF_W-1:0]);
      end
      MAP_LINE: begin
        bank_w = split_bank(addr, 0);
        off_w  = split_off(addr, 0);
      end
      default: begin
        bank_w = split_bank(addr, LN);
        off_w  = split_off(addr, LN);
      end
    endcase
  end

  assign bank   = bank_w[LB-1:0];
  assign offset = off_w[OFF_W-1:0];
endmodule

// File: rtl/rr_port_picker.sv
module rr_port_picker #(
  parameter int NUM_PORTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_PORTS-1:0]         req,
  input  logic                         take,
  output logic [NUM_PORTS-1:0]         grant,
  output logic [$clog2(NUM_PORTS)-1:0] grant_idx,
  output logic                         any
);
  localparam int PW = $clog2(NUM_PORTS);

  logic [PW-1:0] ptr;

  always_comb begin
    any       = 1'b0;
    grant_idx = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (!any && req[PW'(ptr + PW'(k))]) begin
        any       = 1'b1;
        grant_idx = PW'(ptr + PW'(k));
      end
    end
    grant = any ? (NUM_PORTS'(1) << grant_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (take && any) begin
      ptr <= grant_idx + PW'(1);
    end
  end
endmodule

// File: rtl/bank_router.sv
module bank_router
  import bank_router_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_BANKS  = 8,
  parameter int ADDR_W     = 12,
  parameter int LINE_WORDS = 4,
  parameter int BLOCK_WAYS = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [1:0]                            mode,
  input  logic [NUM_PORTS-1:0]                  req_valid,
  input  logic [NUM_PORTS*ADDR_W-1:0]           req_addr,
  output logic [NUM_PORTS-1:0]                  req_ready,
  output logic [NUM_BANKS-1:0]                  bank_valid,
  input  logic [NUM_BANKS-1:0]                  bank_ready,
  output logic [ADDR_W-$clog2(NUM_BANKS)-1:0]   bank_offset,
  output logic [$clog2(NUM_PORTS)-1:0]          bank_src
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int OFF_W  = ADDR_W - BANK_W;
  localparam int PORT_W = $clog2(NUM_PORTS);

  logic              out_valid;
  logic [BANK_W-1:0] out_bank;
  logic [OFF_W-1:0]  out_off;
  logic [PORT_W-1:0] out_src;

  logic              accept;
  logic              load;
  logic              any;
  logic [NUM_PORTS-1:0] grant;
  logic [PORT_W-1:0] gidx;
  logic [ADDR_W-1:0] sel_addr;
  logic [BANK_W-1:0] dec_bank;
  logic [OFF_W-1:0]  dec_off;

  assign accept = out_valid && bank_ready[out_bank];
  assign load   = !out_valid || accept;

  rr_port_picker #(.NUM_PORTS(NUM_PORTS)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .req       (req_valid),
    .take      (load),
    .grant     (grant),
    .grant_idx (gidx),
    .any       (any)
  );

  assign sel_addr = req_addr[gidx*ADDR_W +: ADDR_W];

  bank_addr_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_BANKS  (NUM_BANKS),
    .LINE_WORDS (LINE_WORDS),
    .BLOCK_WAYS (BLOCK_WAYS)
  ) u_dec (
    .addr   (sel_addr),
    .mode   (map_mode_e'(mode)),
    .bank   (dec_bank),
    .offset (dec_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bank  <= '0;
      out_off   <= '0;
      out_src   <= '0;
    end else if (load) begin
      out_valid <= any;
      if (any) begin
        out_bank <= dec_bank;
        out_off  <= dec_off;
        out_src  <= gidx;
      end
    end
  end

  assign req_ready   = load ? grant : '0;
  assign bank_offset = out_off;
  assign bank_src    = out_src;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
    assign bank_valid[b] = out_valid && (out_bank == BANK_W'(b));
  end
endmodule

// File: rtl/bank_router_chk.sv
module bank_router_chk #(
  parameter int NP    = 4,
  parameter int NB    = 8,
  parameter int OFF_W = 9,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NP-1:0]    req_valid,
  input logic [NP-1:0]    req_ready,
  input logic [NB-1:0]    bank_valid,
  input logic [NB-1:0]    bank_ready,
  input logic [OFF_W-1:0] bank_offset,
  input logic [PW-1:0]    bank_src
);
  logic stalled;
  assign stalled = |(bank_valid & ~bank_ready);

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> bank_valid == '0);

  assert_one_bank_R6: assert property (@(posedge clk) disable iff (rst) $onehot0(bank_valid));

  assert_one_port_R7: assert property (@(posedge clk) disable iff (rst) $onehot0(req_ready));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    stalled |=> ($stable(bank_valid) && $stable(bank_offset) && $stable(bank_src)));

  assert_no_take_R9: assert property (@(posedge clk) disable iff (rst)
    stalled |-> req_ready == '0);

  assert_ready_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  assert_forward_R11: assert property (@(posedge clk) disable iff (rst)
    (|req_ready) |=> (|bank_valid));
endmodule

bind bank_router bank_router_chk #(
  .NP(NUM_PORTS), .NB(NUM_BANKS), .OFF_W(OFF_W), .PW(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .bank_valid(bank_valid), .bank_ready(bank_ready),
  .bank_offset(bank_offset), .bank_src(bank_src)
);

// File: tb/bank_router_bench.sv
`timescale 1ns/1ps
module bank_router_bench;
  localparam int NP = 4;
  localparam int NB = 8;
  localparam int AW = 12;
  localparam int OW = 9;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode;
  logic [NP-1:0] req_valid;
  logic [NP*AW-1:0] req_addr;
  logic [NP-1:0] req_ready;
  logic [NB-1:0] bank_valid;
  logic [NB-1:0] bank_ready;
  logic [OW-1:0] bank_offset;
  logic [1:0]    bank_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bank_router u_bank_router (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .bank_valid(bank_valid), .bank_ready(bank_ready),
    .bank_offset(bank_offset), .bank_src(bank_src)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void expect_map(input int m, input logic [AW-1:0] a,
                                     output int eb, output int eo);
    case (m)
      0: begin eb = int'(a[2:0]);  eo = int'(a[11:3]); end
      1: begin eb = int'(a[11:9]); eo = int'(a[8:0]); end
      2: begin eb = int'(a[4:2]);  eo = int'({a[11:5], a[1:0]}); end
      default: begin eb = int'({a[4:3], a[0]}); eo = int'({a[11:5], a[2:1]}); end
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = '0; req_addr = '0; mode = 2'd0; bank_ready = '1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 bank_valid after reset", int'(bank_valid), 0);
    #1 check("R1 req_ready idle", int'(req_ready), 0);
  endtask

  task automatic send_one(input string tag, input int m, input int p, input logic [AW-1:0] a);
    int eb, eo;
    expect_map(m, a, eb, eo);
    mode = 2'(m);
    req_valid = '0;
    req_valid[p] = 1'b1;
    req_addr[p*AW +: AW] = a;
    #1 check({tag, " R10 req_ready"}, int'(req_ready), 1 << p);
    @(negedge clk);
    req_valid = '0;
    check({tag, " R6 bank strobe"}, int'(bank_valid), 1 << eb);
    check({tag, " offset"}, int'(bank_offset), eo);
    check({tag, " R6 source"}, int'(bank_src), p);
  endtask

  task automatic t_modes();
    do_reset();
    send_one("R2 low", 0, 0, 12'hA5C);
    send_one("R2 low", 0, 3, 12'h017);
    send_one("R3 high", 1, 1, 12'hA5C);
    send_one("R3 high", 1, 2, 12'hE01);
    send_one("R4 line", 2, 0, 12'h3B6);
    send_one("R4 line", 2, 1, 12'hFFD);
    send_one("R5 block", 3, 2, 12'h3B6);
    send_one("R5 block", 3, 3, 12'h819);
    @(negedge clk);
    check("R6 drained", int'(bank_valid), 0);
  endtask

  task automatic t_rotate();
    do_reset();
    mode = 2'd0;
    for (int p = 0; p < NP; p++) req_addr[p*AW +: AW] = AW'(p * 9 + 1);
    req_valid = '1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R7 rotation source", int'(bank_src), (k - 1) % NP);
      check("R11 back-to-back strobe", int'(|bank_valid), 1);
    end
    req_valid = '0;
    @(negedge clk);
  endtask

  task automatic t_skip();
    int seq[4] = '{1, 3, 1, 3};
    do_reset();
    mode = 2'd1;
    req_addr = '0;
    req_valid = 4'b1010;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 skip idle ports", int'(bank_src), seq[k]);
    end
    req_valid = '0;
    @(negedge clk);
  endtask

  task automatic t_stall();
    logic [AW-1:0] a = 12'h135;
    logic [AW-1:0] b = 12'h24A;
    do_reset();
    mode = 2'd0;
    bank_ready = ~(NB'(1) << a[2:0]);
    req_valid = 4'b0100;
    req_addr[2*AW +: AW] = a;
    @(negedge clk);
    req_valid = 4'b0001;
    req_addr[0 +: AW] = b;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R9 held strobe", int'(bank_valid), 1 << a[2:0]);
      check("R9 held offset", int'(bank_offset), int'(a[11:3]));
      check("R9 held source", int'(bank_src), 2);
      check("R9 no ready while stalled", int'(req_ready), 0);
      @(negedge clk);
    end
    bank_ready = '1;
    #1 check("R9 released ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = '0;
    check("R9 next strobe", int'(bank_valid), 1 << b[2:0]);
    check("R9 next source", int'(bank_src), 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; mode = '0; req_valid = '0; req_addr = '0; bank_ready = '1;
    t_reset();
    t_modes();
    t_rotate();
    t_skip();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule